// File: doc/BRIEF.md
# Configuration Request Packet Generator

This block converts a single configuration-space access (read or write) into a four-word request packet on a 32-bit streaming transmit port. The requester supplies the target bus, device, function and register offset, an access size, write data, a read/write select, and two bus numbers: the local root bus and the secondary bus behind the local port. The block latches the request and emits three header words followed by one data word. Each word carries start-of-packet and end-of-packet flags and is held under a valid/ready handshake.

The block selects a type-0 or type-1 request from the bus numbers. It derives the byte enables from the offset and the access size, moves sub-word write data into its byte lane, and uses a fixed tag that differs between reads and writes. A one-cycle completion pulse marks the handshake of the final word, and a new request can be taken in the following cycle. Completion handling, the physical link and local register access are outside this block.

Top module: `cfg_req_packer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, req_ready is 1 and tx_valid and done are 0. Asserting reset in the middle of a packet drops it.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. All request inputs, including root_bus and sec_bus, are captured on that edge. In the next cycle tx_valid is 1 and word 0 is presented. Request inputs that change while a packet is in flight have no effect on it, and req_ready stays 0 until the packet is done.
- R3: Words go out in the order header 0, header 1, header 2, data. tx_sop is 1 on word 0 only and tx_eop is 1 on word 3 only.
- R4: Word 0 bits 31:24 hold the format/type byte: 0x04 for a type-0 read, 0x44 for a type-0 write, 0x05 for a type-1 read and 0x45 for a type-1 write. Bits 23:0 equal 1, a length of one doubleword.
- R5: Type 1 is used when req_bus is strictly greater than sec_bus. Otherwise type 0 is used.
- R6: Word 1 has root_bus in bits 31:24 and zero in bits 23:16. Bits 15:8 hold the tag, 0x1D for a read and 0x10 for a write. Bits 7:4 are zero and bits 3:0 hold the byte enables.
- R7: The byte enables depend on req_size and on o = req_offset[1:0]. For size 0 (byte) they are 1 shifted left by o. For size 1 (halfword) they are 3 shifted left by o, truncated to 4 bits. For sizes 2 and 3 (word) they are 0xF.
- R8: Word 2 has req_bus in bits 31:24, req_dev in 23:19 and req_fn in 18:16. Bits 15:12 are zero. Bits 11:2 hold req_offset[11:2] and bits 1:0 are zero.
- R9: For a read, word 3 is zero. For a write, word 3 depends on the size. For a byte, req_wdata[7:0] is shifted left by 8·o. For a halfword, req_wdata[15:0] is shifted left by 8·o and truncated to 32 bits. For a word, req_wdata is sent unshifted.
- R10: While tx_valid is 1 and tx_ready is 0, tx_data, tx_sop and tx_eop hold their values.
- R11: done is 1 for exactly the cycle in which word 3 is handed over (tx_valid, tx_ready and tx_eop all 1). req_ready is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_offset | input | OFS_W (12) | Register byte offset |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_wdata | input | 32 | Write data, right-aligned |
| root_bus | input | 8 | Local root bus number (requester ID) |
| sec_bus | input | 8 | Secondary bus number |
| tx_valid | output | 1 | Output word valid |
| tx_ready | input | 1 | Sink accepts word |
| tx_data | output | 32 | Output word |
| tx_sop | output | 1 | First word of packet |
| tx_eop | output | 1 | Last word of packet |
| done | output | 1 | Final word handed over this cycle |

## Verification
Two events can fall in the same cycle: the handover of the final word, which raises done, and a new request that is already waiting on req_valid. The bench provokes this by raising a second request while the first packet is still in flight and holding it through the last handshake. It then checks three things: the packet in flight still carries only the first request's fields; req_ready is 1 and tx_valid is 0 in the cycle after done; and the second request's word 0 appears one cycle later. A reset issued mid-packet and a multi-cycle stall of tx_ready on a header word are also judged at the ports.

// File: rtl/cfg_req_packer.sv
module cfg_req_packer #(
  parameter int   OFS_W     = 12,
  parameter logic [7:0] READ_TAG  = 8'h1D,
  parameter logic [7:0] WRITE_TAG = 8'h10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [7:0]       req_bus,
  input  logic [4:0]       req_dev,
  input  logic [2:0]       req_fn,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [1:0]       req_size,
  input  logic [31:0]      req_wdata,
  input  logic [7:0]       root_bus,
  input  logic [7:0]       sec_bus,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [31:0]      tx_data,
  output logic             tx_sop,
  output logic             tx_eop,
  output logic             done
);

  localparam logic [1:0] LAST = 2'd3;

  logic             busy;
  logic [1:0]       idx;
  logic             wr_q;
  logic [1:0]       size_q;
  logic [7:0]       bus_q, root_q, sec_q;
  logic [4:0]       dev_q;
  logic [2:0]       fn_q;
  logic [OFS_W-1:0] ofs_q;
  logic [31:0]      wdata_q;

  wire take = req_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= 2'd0;
    end else if (take) begin
      busy <= 1'b1;
      idx  <= 2'd0;
    end else if (busy && tx_ready) begin
      idx <= idx + 2'd1;
      if (idx == LAST) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      wr_q    <= req_write;
      size_q  <= req_size;
      bus_q   <= req_bus;
      dev_q   <= req_dev;
      fn_q    <= req_fn;
      ofs_q   <= req_offset;
      wdata_q <= req_wdata;
      root_q  <= root_bus;
      sec_q   <= sec_bus;
    end
  end

  logic [3:0]  be;
  logic [31:0] lane;
  logic [4:0]  sh;
  logic [15:0] ofs_ext;
  logic [7:0]  fmt;
  logic [31:0] w0, w1, w2, w3;

  assign sh = {ofs_q[1:0], 3'b000};

  always_comb begin
    case (size_q)
      2'd0:    be = 4'b0001 << ofs_q[1:0];
      2'd1:    be = 4'b0011 << ofs_q[1:0];
      default: be = 4'b1111;
    endcase
  end

  always_comb begin
    case (size_q)
      2'd0:    lane = {24'd0, wdata_q[7:0]} << sh;
      2'd1:    lane = {16'd0, wdata_q[15:0]} << sh;
      default: lane = wdata_q;
    endcase
  end

  assign ofs_ext = 16'(ofs_q) & 16'hFFFC;
  assign fmt     = {1'b0, wr_q, 5'b00010, (bus_q > sec_q)};

  assign w0 = {fmt, 14'd0, 10'd1};
  assign w1 = {root_q, 8'h00, (wr_q ? WRITE_TAG : READ_TAG), 4'h0, be};
  assign w2 = {bus_q, dev_q, fn_q, ofs_ext};
  assign w3 = wr_q ? lane : 32'd0;

  always_comb begin
    case (idx)
      2'd0:    tx_data = w0;
      2'd1:    tx_data = w1;
      2'd2:    tx_data = w2;
      default: tx_data = w3;
    endcase
  end

  assign req_ready = !busy;
  assign tx_valid  = busy;
  assign tx_sop    = busy && (idx == 2'd0);
  assign tx_eop    = busy && (idx == LAST);
  assign done      = busy && tx_ready && (idx == LAST);

endmodule

// File: rtl/cfg_req_packer_chk.sv
module cfg_req_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [31:0] tx_data,
  input logic        tx_sop,
  input logic        tx_eop,
  input logic        done
);

  // R2
  excl_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready != tx_valid);

  // R2
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (tx_valid && tx_sop));

  // R10
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));

  // R3
  flags_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !(tx_sop && tx_eop));

  // R4
  fmt_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_sop) |-> ((tx_data[31:24] inside {8'h04, 8'h44, 8'h05, 8'h45}) && tx_data[23:0] == 24'd1));

  // R11
  done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tx_valid && tx_ready && tx_eop));

  // R11
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);

endmodule

bind cfg_req_packer cfg_req_packer_chk chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_sop(tx_sop), .tx_eop(tx_eop), .done(done)
);

// File: tb/cfg_req_packer_test.sv
`timescale 1ns/1ps
module cfg_req_packer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_fn = '0;
  logic [11:0] req_offset = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  root_bus = '0;
  logic [7:0]  sec_bus = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic [31:0] tx_data;
  logic        tx_sop, tx_eop, done;

  always #2.5 clk = ~clk;

  cfg_req_packer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn),
    .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
    .root_bus(root_bus), .sec_bus(sec_bus), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop), .done(done)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [11:0] ofs;
    logic [31:0] wd;
    logic [7:0]  root;
    logic [7:0]  sec;
    logic [31:0] e0, e1, e2, e3;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    {1'b0, 2'd2, 8'h01, 5'd0,  3'd0, 12'h000, 32'hDEADBEEF, 8'h00, 8'h01,
     32'h04000001, 32'h00001D0F, 32'h01000000, 32'h00000000},
    {1'b1, 2'd0, 8'h02, 5'd5,  3'd3, 12'h03D, 32'h123456A5, 8'h03, 8'h01,
     32'h45000001, 32'h03001002, 32'h022B003C, 32'h0000A500},
    {1'b0, 2'd1, 8'h09, 5'd31, 3'd7, 12'hFFE, 32'h00000000, 8'h02, 8'h04,
     32'h05000001, 32'h02001D0C, 32'h09FF0FFC, 32'h00000000},
    {1'b1, 2'd1, 8'h05, 5'd1,  3'd0, 12'h007, 32'hCAFE1234, 8'h10, 8'h05,
     32'h44000001, 32'h10001008, 32'h05080004, 32'h34000000},
    {1'b1, 2'd2, 8'h00, 5'd0,  3'd1, 12'h100, 32'h89ABCDEF, 8'hAB, 8'h00,
     32'h44000001, 32'hAB00100F, 32'h00010100, 32'h89ABCDEF},
    {1'b0, 2'd0, 8'h80, 5'd2,  3'd4, 12'h0A3, 32'hFFFFFFFF, 8'h7F, 8'h7F,
     32'h05000001, 32'h7F001D08, 32'h801400A0, 32'h00000000},
    {1'b1, 2'd3, 8'h03, 5'd0,  3'd0, 12'h012, 32'h11223344, 8'h01, 8'h02,
     32'h45000001, 32'h0100100F, 32'h03000010, 32'h11223344}
  };

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic drive(input vec_t v);
    req_write  = v.wr;
    req_size   = v.sz;
    req_bus    = v.bus;
    req_dev    = v.dev;
    req_fn     = v.fn;
    req_offset = v.ofs;
    req_wdata  = v.wd;
    root_bus   = v.root;
    sec_bus    = v.sec;
  endtask

  task automatic issue(input vec_t v);
    chk("R2 ready before request", 32'(req_ready), 32'd1);
    drive(v);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic collect(input vec_t v, input int stall);
    logic [31:0] exp [4];
    exp[0] = v.e0; exp[1] = v.e1; exp[2] = v.e2; exp[3] = v.e3;
    for (int k = 0; k < 4; k++) begin
      if (k == 1 && stall > 0) begin
        tx_ready = 1'b0;
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          chk("R10 word held under stall", tx_data, exp[1]);
          chk("R10 valid held under stall", 32'(tx_valid), 32'd1);
        end
        tx_ready = 1'b1;
      end
      chk("R2 valid during packet", 32'(tx_valid), 32'd1);
      chk("R2 ready low during packet", 32'(req_ready), 32'd0);
      case (k)
        0: chk("R4/R5 header word 0", tx_data, exp[0]);
        1: chk("R6/R7 header word 1", tx_data, exp[1]);
        2: chk("R8 header word 2", tx_data, exp[2]);
        default: chk("R9 data word", tx_data, exp[3]);
      endcase
      chk("R3 sop flag", 32'(tx_sop), 32'(k == 0));
      chk("R3 eop flag", 32'(tx_eop), 32'(k == 3));
      chk("R11 done pulse", 32'(done), 32'(k == 3));
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 32'(req_ready), 32'd1);
    chk("R1 valid in reset", 32'(tx_valid), 32'd0);
    chk("R1 done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 32'(req_ready), 32'd1);
    chk("R1 valid after reset", 32'(tx_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i]);
      collect(VECS[i], (i == 2) ? 3 : 0);
      chk("R11 ready after done", 32'(req_ready), 32'd1);
      chk("R11 valid after done", 32'(tx_valid), 32'd0);
    end

    // R2 and R11: second request pending while first completes
    issue(VECS[1]);
    drive(VECS[4]);
    req_valid = 1'b1;
    collect(VECS[1], 2);
    chk("R11 ready after done with pending request", 32'(req_ready), 32'd1);
    chk("R11 idle gap after done", 32'(tx_valid), 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    drive(VECS[0]);
    collect(VECS[4], 0);
    chk("R2 back to idle", 32'(req_ready), 32'd1);

    // R1: reset in the middle of a packet
    issue(VECS[3]);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 valid dropped by reset", 32'(tx_valid), 32'd0);
    chk("R1 ready after mid-packet reset", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 still idle after release", 32'(tx_valid), 32'd0);
    issue(VECS[5]);
    collect(VECS[5], 1);
    chk("R11 idle after recovery packet", 32'(req_ready), 32'd1);

    summary();
  end

endmodule